// File: doc/BRIEF.md
# USB Endpoint Mode Handshake Controller

This block holds the per-endpoint decision logic of a USB device engine. The upstream packet logic hands it transactions that are already decoded: the token class, the endpoint number, whether the packet passed its error checks, the received byte count and the DATA0/DATA1 bit. From a 4-bit mode held per endpoint, the block picks one of four outcomes: ACK, NAK, STALL or silence. When a transaction is acknowledged, the block rewrites that mode by itself. A mode that acknowledged a packet moves to the matching NAK mode, so firmware must re-arm the endpoint before more data can flow.

Each endpoint also has a count register and three token status flags, which the CPU reads and writes through a small register port. Endpoint 0 is the control endpoint. After any acknowledged transaction on it, CPU writes to its registers are shut out until the CPU reads one of them. This stops firmware from overwriting a fresh SETUP result with a stale value. An interrupt pulse marks each completed transaction, and also each received packet on a listening endpoint that fails its CRC.

The upstream logic holds `tok_type` and `tok_ep` steady from the token until the end of the transaction. It pulses `data_begin` when the data phase starts and `xact_end` when the transaction ends. For an IN, `xact_ok` high means the host acknowledged the data. For OUT and SETUP it means the packet passed CRC and error checks.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset, every endpoint reads mode 0000 with status flags 0 and count register 0x00, and `hs_valid` and `irq` are low.
- R2: Mode 0000 gives no reply to any token. An IN to the OUT-only modes (1000, 1001) and an OUT or SETUP to the IN-only modes (1100, 1101) also get no reply. An ignored token leaves the mode, the flags and the count unchanged.
- R3: A valid SETUP to a mode that accepts SETUP (0001, 0011, 1010, 1110, 1111) is answered with ACK, and the mode becomes 0001.
- R4: An acknowledged transaction in one of the mode transitions below moves the mode to its NAK counterpart:
  - 1001 becomes 1000.
  - 1101 becomes 1100.
  - 1111 becomes 1110, for either an IN or an OUT.
- R5: Modes 1010 and 1110 keep their value after an acknowledged OUT.
- R6: Modes 0001 and 0011 answer IN and OUT with NAK and STALL respectively. The mode and the count register stay unchanged.
- R7: An OUT or SETUP is valid only when `xact_ok` is high and `xact_cnt` is below EP_SIZE+2. An invalid transaction gets no reply and changes no mode.
- R8: The count register (`cpu_sel`=1) holds the DATA toggle in bit 7, a data-good flag in bit 6 and the byte count in bits 5..0. It is loaded on an acknowledged OUT or SETUP with the good flag set. It is also loaded on a CRC failure to an endpoint whose mode replies to that token, with the good flag clear.
- R9: The mode register (`cpu_sel`=0) reads as {SETUP flag, IN flag, OUT flag, 0, mode}:
  - The IN and OUT flags set when a transaction of that kind is acknowledged.
  - The SETUP flag sets when the data phase of an accepted SETUP begins.
  - A CPU write loads the flags from bits 7..5 and the mode from bits 3..0.
- R10: After an acknowledged transaction on endpoint 0, CPU writes to both of its registers are dropped. This lasts until a cycle with `cpu_re` high and `cpu_ep`=0, and `cpu_rdata` shows the current value during that cycle. Other endpoints never lock.
- R11: `irq` pulses for one cycle, one cycle after `xact_end`, on an acknowledged transaction. It also pulses on a CRC-failed OUT or SETUP to an endpoint that replies to that token. It stays low for NAK, STALL and ignored tokens.
- R12: Mode codes outside the defined set (for example 0101) behave exactly as 0000.
- R13: `hs_valid` is a one-cycle pulse in the cycle after `xact_end`. `hs_code` reads 0 for ACK, 1 for NAK and 2 for STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_type | input | 2 | Token class: 0 OUT, 1 IN, 2 SETUP, 3 none |
| tok_ep | input | EP_W | Endpoint addressed by the token |
| data_begin | input | 1 | Pulse at start of the data phase |
| xact_end | input | 1 | Pulse at end of the transaction |
| xact_ok | input | 1 | Packet passed checks (IN: host acknowledged) |
| xact_cnt | input | 6 | Received byte count including CRC |
| xact_tog | input | 1 | Received DATA0/DATA1 bit |
| cpu_ep | input | EP_W | Endpoint selected by the CPU |
| cpu_sel | input | 1 | 0 mode register, 1 count register |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe (unlocks endpoint 0) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register, combinational |
| hs_valid | output | 1 | Handshake reply present |
| hs_code | output | 2 | Reply: 0 ACK, 1 NAK, 2 STALL |
| irq | output | 1 | Interrupt pulse |

## Verification
A transaction's reply, interrupt and register updates are all captured on the edge that samples `xact_end`. The bench raises `xact_end` at a falling edge and drops it at the next falling edge, then reads `hs_valid`, `hs_code` and `irq` at that point, exactly one cycle after the stimulus. `cpu_rdata` is combinational, so register contents, including the value returned during an unlocking read, are checked 1 ns after the selecting inputs change, with no edge in between. CPU writes and `data_begin` take effect on a single edge and are checked at the following falling edge.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

    typedef enum logic [1:0] {
        TK_OUT   = 2'd0,
        TK_IN    = 2'd1,
        TK_SETUP = 2'd2,
        TK_NONE  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        RS_ACK   = 2'd0,
        RS_NAK   = 2'd1,
        RS_STALL = 2'd2,
        RS_IGN   = 2'd3
    } resp_e;

    typedef struct packed {
        resp_e on_setup;
        resp_e on_in;
        resp_e on_out;
    } mode_resp_t;

    localparam logic [3:0] M_OFF          = 4'b0000;
    localparam logic [3:0] M_NAK_BOTH     = 4'b0001;
    localparam logic [3:0] M_STALL_BOTH   = 4'b0011;
    localparam logic [3:0] M_RX_NAK       = 4'b1000;
    localparam logic [3:0] M_RX_ACK       = 4'b1001;
    localparam logic [3:0] M_STATUS_RX    = 4'b1010;
    localparam logic [3:0] M_TX_NAK       = 4'b1100;
    localparam logic [3:0] M_TX_ACK       = 4'b1101;
    localparam logic [3:0] M_TX_NAK_ST    = 4'b1110;
    localparam logic [3:0] M_TX_ACK_ST    = 4'b1111;

    function automatic mode_resp_t mode_table(input logic [3:0] m);
        mode_resp_t r;
        r = '{on_setup: RS_IGN, on_in: RS_IGN, on_out: RS_IGN};
        case (m)
            M_NAK_BOTH:   r = '{on_setup: RS_ACK, on_in: RS_NAK,   on_out: RS_NAK};
            M_STALL_BOTH: r = '{on_setup: RS_ACK, on_in: RS_STALL, on_out: RS_STALL};
            M_RX_NAK:     r.on_out = RS_NAK;
            M_RX_ACK:     r.on_out = RS_ACK;
            M_STATUS_RX:  r = '{on_setup: RS_ACK, on_in: RS_STALL, on_out: RS_ACK};
            M_TX_NAK:     r.on_in = RS_NAK;
            M_TX_ACK:     r.on_in = RS_ACK;
            M_TX_NAK_ST:  r = '{on_setup: RS_ACK, on_in: RS_NAK,   on_out: RS_ACK};
            M_TX_ACK_ST:  r = '{on_setup: RS_ACK, on_in: RS_ACK,   on_out: RS_ACK};
            default:      ;
        endcase
        return r;
    endfunction

    function automatic logic [3:0] mode_after_ack(input logic [3:0] m, input tok_e t);
        logic [3:0] n;
        n = m;
        if (t == TK_SETUP) begin
            n = M_NAK_BOTH;
        end else begin
            case (m)
                M_RX_ACK:    n = M_RX_NAK;
                M_TX_ACK:    n = M_TX_NAK;
                M_TX_ACK_ST: n = M_TX_NAK_ST;
                default:     n = m;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/usb_ep_decode.sv
module usb_ep_decode
    import usb_ep_pkg::*;
(
    input  logic [3:0] mode,
    input  tok_e       tok,
    output resp_e      resp,
    output logic [3:0] mode_ack
);
    mode_resp_t row;

    always_comb begin
        row = mode_table(mode);
        case (tok)
            TK_SETUP: resp = row.on_setup;
            TK_IN:    resp = row.on_in;
            TK_OUT:   resp = row.on_out;
            default:  resp = RS_IGN;
        endcase
        mode_ack = mode_after_ack(mode, tok);
    end

    always_comb begin
        if (mode == M_OFF) begin
            a_r2_off_silent: assert (resp == RS_IGN);
        end
    end
endmodule

// File: rtl/usb_ep_regs.sv
module usb_ep_regs (
    input  logic       clk,
    input  logic       rst,
    input  logic       eng_mode_we,
    input  logic [3:0] eng_mode,
    input  logic [2:0] eng_stat_set,
    input  logic       eng_cnt_we,
    input  logic [7:0] eng_cnt,
    input  logic       cpu_mode_we,
    input  logic       cpu_cnt_we,
    input  logic [7:0] cpu_wdata,
    output logic [3:0] mode_q,
    output logic [2:0] stat_q,
    output logic [7:0] cnt_q
);
    logic [2:0] stat_base;

    always_comb begin
        stat_base = cpu_mode_we ? cpu_wdata[7:5] : stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 4'b0000;
            stat_q <= 3'b000;
            cnt_q  <= 8'h00;
        end else begin
            if (eng_mode_we)      mode_q <= eng_mode;
            else if (cpu_mode_we) mode_q <= cpu_wdata[3:0];
            stat_q <= stat_base | eng_stat_set;
            if (eng_cnt_we)       cnt_q <= eng_cnt;
            else if (cpu_cnt_we)  cnt_q <= cpu_wdata;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == 4'b0000 && stat_q == 3'b000 && cnt_q == 8'h00));

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !cpu_mode_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
    import usb_ep_pkg::*;
#(
    parameter int NUM_EP  = 4,
    parameter int EP_SIZE = 8,
    parameter int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      tok_type,
    input  logic [EP_W-1:0] tok_ep,
    input  logic            data_begin,
    input  logic            xact_end,
    input  logic            xact_ok,
    input  logic [5:0]      xact_cnt,
    input  logic            xact_tog,
    input  logic [EP_W-1:0] cpu_ep,
    input  logic            cpu_sel,
    input  logic            cpu_we,
    input  logic            cpu_re,
    input  logic [7:0]      cpu_wdata,
    output logic [7:0]      cpu_rdata,
    output logic            hs_valid,
    output logic [1:0]      hs_code,
    output logic            irq
);
    localparam logic [6:0] CNT_LIMIT = 7'(EP_SIZE + 2);

    logic [3:0] mode_a [NUM_EP];
    logic [2:0] stat_a [NUM_EP];
    logic [7:0] cnt_a  [NUM_EP];

    tok_e       tk;
    logic       ep_ok, cpu_ep_ok;
    logic [3:0] cur_mode, ack_mode;
    resp_e      resp;
    logic       is_rx, pkt_ok, responds, fire, acked, crc_bad;
    logic       lock_q;

    always_comb begin
        tk        = tok_e'(tok_type);
        ep_ok     = 32'(tok_ep) < NUM_EP;
        cpu_ep_ok = 32'(cpu_ep) < NUM_EP;
        cur_mode  = ep_ok ? mode_a[tok_ep] : 4'b0000;
    end

    usb_ep_decode u_decode (
        .mode     (cur_mode),
        .tok      (tk),
        .resp     (resp),
        .mode_ack (ack_mode)
    );

    always_comb begin
        is_rx    = (tk == TK_OUT) || (tk == TK_SETUP);
        pkt_ok   = xact_ok && (!is_rx || ({1'b0, xact_cnt} < CNT_LIMIT));
        responds = ep_ok && (resp != RS_IGN);
        fire     = xact_end && responds && pkt_ok;
        acked    = fire && (resp == RS_ACK);
        crc_bad  = xact_end && responds && is_rx && !xact_ok;
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic       hit, cpu_hit, blocked;
        logic [2:0] stat_set;

        always_comb begin
            hit      = 32'(tok_ep) == e;
            cpu_hit  = 32'(cpu_ep) == e;
            blocked  = (e == 0) ? lock_q : 1'b0;
            stat_set = {data_begin && hit && tk == TK_SETUP && resp == RS_ACK,
                        acked && hit && tk == TK_IN,
                        acked && hit && tk == TK_OUT};
        end

        usb_ep_regs u_regs (
            .clk          (clk),
            .rst          (rst),
            .eng_mode_we  (acked && hit),
            .eng_mode     (ack_mode),
            .eng_stat_set (stat_set),
            .eng_cnt_we   (hit && ((acked && is_rx) || crc_bad)),
            .eng_cnt      ({xact_tog, acked, xact_cnt}),
            .cpu_mode_we  (cpu_we && cpu_hit && !cpu_sel && !blocked),
            .cpu_cnt_we   (cpu_we && cpu_hit && cpu_sel && !blocked),
            .cpu_wdata    (cpu_wdata),
            .mode_q       (mode_a[e]),
            .stat_q       (stat_a[e]),
            .cnt_q        (cnt_a[e])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (acked && tok_ep == '0) begin
            lock_q <= 1'b1;
        end else if (cpu_re && cpu_ep == '0) begin
            lock_q <= 1'b0;
        end
    end

    always_comb begin
        if (!cpu_ep_ok)   cpu_rdata = 8'h00;
        else if (cpu_sel) cpu_rdata = cnt_a[cpu_ep];
        else              cpu_rdata = {stat_a[cpu_ep], 1'b0, mode_a[cpu_ep]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid <= 1'b0;
            hs_code  <= RS_ACK;
            irq      <= 1'b0;
        end else begin
            hs_valid <= fire;
            hs_code  <= resp;
            irq      <= acked || crc_bad;
        end
    end

    logic [3:0] mode0;
    assign mode0 = mode_a[0];

    a_r13_reply_timing: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> $past(xact_end));
    a_r13_reply_code: assert property (@(posedge clk) disable iff (rst)
        hs_valid |-> (hs_code != RS_IGN));
    a_r7_reject_silent: assert property (@(posedge clk) disable iff (rst)
        (xact_end && !pkt_ok) |=> !hs_valid);
    a_r3_setup_rearm: assert property (@(posedge clk) disable iff (rst)
        (acked && tk == TK_SETUP && tok_ep == '0) |=> (mode0 == M_NAK_BOTH));
    a_r10_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (lock_q && cpu_we && cpu_ep == '0 && !cpu_sel && !(xact_end && tok_ep == '0))
        |=> $stable(mode0));
    a_r11_irq_timing: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(xact_end));
endmodule

// File: tb/usb_ep_hs_ctrl_bench.sv
`timescale 1ns/100ps
module usb_ep_hs_ctrl_bench;
    localparam int EP_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] tok_type = 2'd3;
    logic [EP_W-1:0] tok_ep = '0;
    logic data_begin = 1'b0, xact_end = 1'b0, xact_ok = 1'b0, xact_tog = 1'b0;
    logic [5:0] xact_cnt = '0;
    logic [EP_W-1:0] cpu_ep = '0;
    logic cpu_sel = 1'b0, cpu_we = 1'b0, cpu_re = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic hs_valid, irq;
    logic [1:0] hs_code;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    usb_ep_hs_ctrl u_usb_ep_hs_ctrl (
        .clk(clk), .rst(rst), .tok_type(tok_type), .tok_ep(tok_ep),
        .data_begin(data_begin), .xact_end(xact_end), .xact_ok(xact_ok),
        .xact_cnt(xact_cnt), .xact_tog(xact_tog), .cpu_ep(cpu_ep),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .hs_valid(hs_valid),
        .hs_code(hs_code), .irq(irq)
    );

    localparam logic [1:0] T_OUT = 2'd0, T_IN = 2'd1, T_SETUP = 2'd2;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [EP_W-1:0] ep, input logic sel, input string req,
                      input logic [7:0] exp);
        cpu_ep = ep; cpu_sel = sel;
        #1;
        chk(req, cpu_rdata, exp);
    endtask

    task automatic wr(input logic [EP_W-1:0] ep, input logic sel, input logic [7:0] d);
        @(negedge clk);
        cpu_ep = ep; cpu_sel = sel; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    // transaction; checks reply {valid,code} and irq one cycle after xact_end
    task automatic xact(input logic [1:0] t, input logic [EP_W-1:0] ep, input logic ok,
                        input logic [5:0] cnt, input logic tog, input string req,
                        input logic exp_v, input logic [1:0] exp_c, input logic exp_irq);
        @(negedge clk);
        tok_type = t; tok_ep = ep; xact_ok = ok; xact_cnt = cnt; xact_tog = tog;
        xact_end = 1'b1;
        @(negedge clk);
        xact_end = 1'b0;
        chk({req, " hs_valid"}, {7'd0, hs_valid}, {7'd0, exp_v});
        if (exp_v) chk({req, " hs_code"}, {6'd0, hs_code}, {6'd0, exp_c});
        chk({req, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
        tok_type = 2'd3;
    endtask

    task automatic t_reset;
        for (int e = 0; e < 4; e++) begin
            rd(EP_W'(e), 1'b0, "R1 mode after reset", 8'h00);
            rd(EP_W'(e), 1'b1, "R1 count after reset", 8'h00);
        end
        chk("R1 hs_valid after reset", {7'd0, hs_valid}, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_disabled;
        xact(T_OUT,   1, 1'b1, 6'd4, 1'b0, "R2 OUT to off", 1'b0, 2'd0, 1'b0);
        xact(T_IN,    1, 1'b1, 6'd0, 1'b0, "R2 IN to off", 1'b0, 2'd0, 1'b0);
        xact(T_SETUP, 1, 1'b1, 6'd9, 1'b0, "R2 SETUP to off", 1'b0, 2'd0, 1'b0);
        rd(1, 1'b0, "R2 mode unchanged", 8'h00);
        rd(1, 1'b1, "R2 count unchanged", 8'h00);
        wr(3, 1'b0, 8'h05);
        xact(T_SETUP, 3, 1'b1, 6'd9, 1'b0, "R12 SETUP to code 0101", 1'b0, 2'd0, 1'b0);
        xact(T_OUT,   3, 1'b1, 6'd3, 1'b0, "R12 OUT to code 0101", 1'b0, 2'd0, 1'b0);
        rd(3, 1'b0, "R12 mode kept", 8'h05);
    endtask

    task automatic t_setup_lock;
        wr(0, 1'b0, 8'h0F);
        rd(0, 1'b0, "R9 cpu write mode", 8'h0F);
        @(negedge clk);
        tok_type = T_SETUP; tok_ep = 0; data_begin = 1'b1;
        @(negedge clk);
        data_begin = 1'b0;
        rd(0, 1'b0, "R9 setup flag at data begin", 8'h8F);
        xact(T_SETUP, 0, 1'b1, 6'd9, 1'b0, "R3 SETUP ack", 1'b1, 2'd0, 1'b1);
        rd(0, 1'b0, "R3 mode forced to 0001", 8'h81);
        rd(0, 1'b1, "R8 count reg after SETUP", 8'h49);
        wr(0, 1'b0, 8'h0F);
        rd(0, 1'b0, "R10 locked mode write dropped", 8'h81);
        wr(0, 1'b1, 8'h00);
        rd(0, 1'b1, "R10 locked count write dropped", 8'h49);
        @(negedge clk);
        cpu_ep = 0; cpu_sel = 1'b0; cpu_re = 1'b1;
        #1;
        chk("R10 unlocking read value", cpu_rdata, 8'h81);
        @(negedge clk);
        cpu_re = 1'b0;
        wr(0, 1'b0, 8'h0F);
        rd(0, 1'b0, "R10 write after unlock", 8'h0F);
    endtask

    task automatic t_auto;
        wr(1, 1'b0, 8'h09);
        xact(T_OUT, 1, 1'b1, 6'd5, 1'b1, "R4 OUT ack in 1001", 1'b1, 2'd0, 1'b1);
        rd(1, 1'b0, "R4 1001 to 1000 with OUT flag", 8'h28);
        rd(1, 1'b1, "R8 count reg after OUT", 8'hC5);
        xact(T_IN, 1, 1'b1, 6'd0, 1'b0, "R2 IN to OUT-only mode", 1'b0, 2'd0, 1'b0);
        rd(1, 1'b0, "R2 OUT-only mode unchanged", 8'h28);
        wr(1, 1'b0, 8'h0D);
        rd(1, 1'b0, "R10 ep1 write never locked", 8'h0D);
        xact(T_IN, 1, 1'b1, 6'd0, 1'b0, "R4 IN ack in 1101", 1'b1, 2'd0, 1'b1);
        rd(1, 1'b0, "R4 1101 to 1100 with IN flag", 8'h4C);
        rd(1, 1'b1, "R8 IN leaves count", 8'hC5);
        wr(2, 1'b0, 8'h0F);
        xact(T_OUT, 2, 1'b1, 6'd2, 1'b0, "R4 status OUT in 1111", 1'b1, 2'd0, 1'b1);
        rd(2, 1'b0, "R4 1111 to 1110", 8'h2E);
        xact(T_OUT, 2, 1'b1, 6'd2, 1'b0, "R5 OUT ack in 1110", 1'b1, 2'd0, 1'b1);
        rd(2, 1'b0, "R5 1110 kept", 8'h2E);
        wr(3, 1'b0, 8'h0A);
        xact(T_OUT, 3, 1'b1, 6'd2, 1'b0, "R5 OUT ack in 1010", 1'b1, 2'd0, 1'b1);
        rd(3, 1'b0, "R5 1010 kept", 8'h2A);
    endtask

    task automatic t_nak_stall;
        wr(1, 1'b0, 8'h01);
        xact(T_IN, 1, 1'b1, 6'd0, 1'b0, "R6 IN NAK in 0001", 1'b1, 2'd1, 1'b0);
        rd(1, 1'b0, "R6 0001 kept", 8'h01);
        wr(1, 1'b0, 8'h03);
        xact(T_OUT, 1, 1'b1, 6'd3, 1'b0, "R6 OUT STALL in 0011", 1'b1, 2'd2, 1'b0);
        rd(1, 1'b0, "R6 0011 kept", 8'h03);
        rd(1, 1'b1, "R6 count unchanged by STALL", 8'hC5);
    endtask

    task automatic t_invalid;
        wr(2, 1'b0, 8'h09);
        xact(T_OUT, 2, 1'b1, 6'd10, 1'b0, "R7 count at limit", 1'b0, 2'd0, 1'b0);
        rd(2, 1'b0, "R7 mode unchanged", 8'h09);
        xact(T_OUT, 2, 1'b1, 6'd9, 1'b0, "R7 count below limit", 1'b1, 2'd0, 1'b1);
        rd(2, 1'b0, "R7 accepted OUT moves mode", 8'h28);
        rd(2, 1'b1, "R8 count reg 9 bytes", 8'h49);
        wr(2, 1'b0, 8'h09);
        xact(T_OUT, 2, 1'b0, 6'd4, 1'b1, "R11 bad CRC irq", 1'b0, 2'd0, 1'b1);
        rd(2, 1'b1, "R8 bad CRC clears data-good", 8'h84);
        rd(2, 1'b0, "R7 bad CRC keeps mode", 8'h09);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_setup_lock;
        t_auto;
        t_nak_stall;
        t_invalid;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule